// File: doc/BRIEF.md
# Flag Offset Register Programmer

This block holds the four threshold offsets that drive the almost-full and almost-empty flags of a pair of FIFOs. The offsets are one almost-full and one almost-empty offset for FIFO 1, and the same two for FIFO 2. Each offset is as wide as the FIFO pointer, which the block derives from its `DEPTH` parameter. It does not contain the FIFO memory or the flag comparators. It only produces the offset values and a `prog_done` status that tells the rest of the FIFO when the offsets are valid.

The way the offsets get their values is fixed while master reset is held low. The serial-mode pin and two dual-purpose configuration pins are captured on every clock of the reset. The values present on the last reset clock decide the method. There are three methods:

- Preset: one of three preset offsets is copied into all four registers.
- Parallel: the next four port-A writes load the registers, one per write.
- Serial: the two configuration pins become a serial enable and a serial data bit, and the four registers act as one shift chain clocked by the port-A clock.

A partial reset is for restarting the FIFO pointers only. It leaves the method, the offsets and the status untouched, and it blocks loading while it is held.

Top module: `flag_offset_loader`

## Requirements
- R1: While `mrst_n` is low at a rising clock edge, all four offsets and `prog_done` go to zero. The pin values on the last such edge decide the method, whatever the pins held on earlier reset edges.
- R2: Decoding of the method, with `sel` meaning the pair {`cfg_hi_en_n`, `cfg_lo_dat`}:
  - `serial_mode_n` low selects serial loading.
  - `serial_mode_n` high with `sel` = 00 selects parallel loading.
  - `serial_mode_n` high with `sel` = 01 selects the preset 8, `sel` = 10 selects 16, and `sel` = 11 selects 64.
- R3: In preset mode, the first rising edge after master reset release with `prst_n` high writes the chosen preset into all four offsets and sets `prog_done`.
- R4: In parallel mode, four edges with `a_wr` high load `afull1_off`, `aempty1_off`, `afull2_off` and `aempty2_off`, in that order. Each load takes `a_data[PTR_W-1:0]`, and the upper data bits are ignored. `prog_done` rises on the edge of the fourth write and not before.
- R5: In serial mode, each edge with `cfg_hi_en_n` low shifts `cfg_lo_dat` into the LSB of `aempty2_off`. The chain runs `afull1_off`, `aempty1_off`, `afull2_off`, `aempty2_off`, each MSB first. As a result, the first bit of a full load ends in the MSB of `afull1_off` and the last bit in the LSB of `aempty2_off`.
- R6: A serial load takes exactly 4*PTR_W accepted bits: 32, 36 and 40 for depths 256, 512 and 1024. `prog_done` rises on the edge of the last bit.
- R7: Once `prog_done` is high, further writes and serial bits leave the offsets unchanged, and `prog_done` stays high until the next master reset.
- R8: While `prst_n` is low, no write, serial bit or preset is accepted. The offsets, `prog_done` and the latched method are kept, and a load in progress resumes where it stopped once `prst_n` returns high.
- R9: In serial mode, an edge with `cfg_hi_en_n` high changes no offset, whatever the value of `cfg_lo_dat`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port-A clock |
| mrst_n | input | 1 | Master reset, synchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| serial_mode_n | input | 1 | Low selects serial programming at master reset |
| cfg_hi_en_n | input | 1 | Upper preset select bit in reset; serial enable (active low) afterwards |
| cfg_lo_dat | input | 1 | Lower preset select bit in reset; serial data afterwards |
| a_wr | input | 1 | Port-A write strobe used by parallel loading |
| a_data | input | BUS_W | Port-A data bus |
| afull1_off | output | PTR_W | Almost-full offset, FIFO 1 |
| aempty1_off | output | PTR_W | Almost-empty offset, FIFO 1 |
| afull2_off | output | PTR_W | Almost-full offset, FIFO 2 |
| aempty2_off | output | PTR_W | Almost-empty offset, FIFO 2 |
| prog_done | output | 1 | Offsets fully programmed |

## Verification
The assertions assume that every master reset is held for at least one clock. They also assume that the configuration pins are only meaningful as a method select while reset is low, and as enable and data afterwards. The stimulus applies every reset for two clocks and changes pins only on falling edges. The first reset clock carries deliberately wrong pin values, so that only the last reset clock can decide the method.

The serial-count assertion relies on a bit counter of its own in the checker, and a partial-reset pulse is placed inside each parallel and serial load. Three instances, one per depth, share a single 40-bit stream, which exercises the different bit counts against one stimulus.

// File: rtl/fol_pkg.sv
// Shared types and helpers for the flag offset loader.
// Assumes pointer widths of at least 7 bits so every preset fits.
package fol_pkg;

    typedef enum logic [1:0] {
        M_PRESET   = 2'd0,
        M_PARALLEL = 2'd1,
        M_SERIAL   = 2'd2
    } method_t;

    // Map the two select pins to a preset offset value (00 is parallel, no preset).
    function automatic logic [6:0] preset_of(input logic [1:0] code);
        case (code)
            2'b01:   return 7'd8;
            2'b10:   return 7'd16;
            2'b11:   return 7'd64;
            default: return 7'd0;
        endcase
    endfunction

endpackage

// File: rtl/fol_mode_latch.sv
// Captures the programming method and preset code while master reset is low.
// The value held on the last reset edge is the one kept afterwards.
// Assumes master reset is asserted for at least one clock before use.
module fol_mode_latch
    import fol_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             serial_mode_n,
    input  logic             sel_hi,
    input  logic             sel_lo,
    output method_t          method,
    output logic [PTR_W-1:0] preset_val
);

    logic [1:0] code_q;

    // Sample the configuration pins on every reset edge.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            code_q <= {sel_hi, sel_lo};
            if (!serial_mode_n)
                method <= M_SERIAL;
            else if ({sel_hi, sel_lo} == 2'b00)
                method <= M_PARALLEL;
            else
                method <= M_PRESET;
        end
    end

    assign preset_val = PTR_W'(preset_of(code_q));

endmodule

// File: rtl/fol_load_seq.sv
// Load sequencer: decides which kind of load happens on each edge,
// counts accepted words or bits and raises the sticky done status.
// Assumes method is stable outside master reset.
module fol_load_seq
    import fol_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic       clk,
    input  logic       mrst_n,
    input  logic       prst_n,
    input  method_t    method,
    input  logic       wr_strobe,
    input  logic       sen_n,
    output logic       shift_en,
    output logic       par_en,
    output logic       preset_en,
    output logic [1:0] par_idx,
    output logic       done
);

    localparam int SER_BITS = 4 * PTR_W;
    localparam int CNT_W    = $clog2(SER_BITS + 1);

    logic             active;
    logic [CNT_W-1:0] cnt_q;
    logic             last_load;

    // Qualify the three load kinds against partial reset and completion.
    always_comb begin
        active    = prst_n && !done;
        shift_en  = active && (method == M_SERIAL) && !sen_n;
        par_en    = active && (method == M_PARALLEL) && wr_strobe;
        preset_en = active && (method == M_PRESET);
        last_load = preset_en
                  || (shift_en && (cnt_q == CNT_W'(SER_BITS - 1)))
                  || (par_en && (cnt_q == CNT_W'(3)));
    end

    assign par_idx = cnt_q[1:0];

    // Count accepted words or bits and hold the done flag.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            if (shift_en || par_en)
                cnt_q <= cnt_q + CNT_W'(1);
            if (last_load)
                done <= 1'b1;
        end
    end

endmodule

// File: rtl/fol_offset_bank.sv
// The four offset registers in chain order: 0 almost-full 1, 1 almost-empty 1,
// 2 almost-full 2, 3 almost-empty 2. Serial bits enter at the LSB of entry 3
// and move towards the MSB of entry 0. Assumes at most one load enable per edge.
module fol_offset_bank #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             shift_en,
    input  logic             par_en,
    input  logic             preset_en,
    input  logic [1:0]       par_idx,
    input  logic             ser_bit,
    input  logic [PTR_W-1:0] par_word,
    input  logic [PTR_W-1:0] preset_val,
    output logic [PTR_W-1:0] off_q [4]
);

    logic chain_in [4];

    for (genvar i = 0; i < 4; i++) begin : g_reg
        if (i == 3) begin : g_tail
            assign chain_in[i] = ser_bit;
        end else begin : g_link
            assign chain_in[i] = off_q[i+1][PTR_W-1];
        end

        // One offset register: clear, preset, parallel word or serial shift.
        always_ff @(posedge clk) begin
            if (!mrst_n)
                off_q[i] <= '0;
            else if (preset_en)
                off_q[i] <= preset_val;
            else if (par_en && (par_idx == 2'(i)))
                off_q[i] <= par_word;
            else if (shift_en)
                off_q[i] <= {off_q[i][PTR_W-2:0], chain_in[i]};
        end
    end

endmodule

// File: rtl/flag_offset_loader.sv
// Top of the flag offset programmer. Ties the method latch, the load
// sequencer and the register bank together. Assumes all inputs are
// synchronous to clk and DEPTH is a power of two of at least 128.
module flag_offset_loader
    import fol_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int BUS_W = 36,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             serial_mode_n,
    input  logic             cfg_hi_en_n,
    input  logic             cfg_lo_dat,
    input  logic             a_wr,
    input  logic [BUS_W-1:0] a_data,
    output logic [PTR_W-1:0] afull1_off,
    output logic [PTR_W-1:0] aempty1_off,
    output logic [PTR_W-1:0] afull2_off,
    output logic [PTR_W-1:0] aempty2_off,
    output logic             prog_done
);

    method_t          method;
    logic [PTR_W-1:0] preset_val;
    logic             shift_en, par_en, preset_en;
    logic [1:0]       par_idx;
    logic [PTR_W-1:0] off_q [4];
    logic             unused_hi_bits;

    assign unused_hi_bits = ^a_data[BUS_W-1:PTR_W];

    fol_mode_latch #(.PTR_W(PTR_W)) u_mode (
        .clk           (clk),
        .mrst_n        (mrst_n),
        .serial_mode_n (serial_mode_n),
        .sel_hi        (cfg_hi_en_n),
        .sel_lo        (cfg_lo_dat),
        .method        (method),
        .preset_val    (preset_val)
    );

    fol_load_seq #(.PTR_W(PTR_W)) u_seq (
        .clk       (clk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .method    (method),
        .wr_strobe (a_wr),
        .sen_n     (cfg_hi_en_n),
        .shift_en  (shift_en),
        .par_en    (par_en),
        .preset_en (preset_en),
        .par_idx   (par_idx),
        .done      (prog_done)
    );

    fol_offset_bank #(.PTR_W(PTR_W)) u_bank (
        .clk        (clk),
        .mrst_n     (mrst_n),
        .shift_en   (shift_en),
        .par_en     (par_en),
        .preset_en  (preset_en),
        .par_idx    (par_idx),
        .ser_bit    (cfg_lo_dat),
        .par_word   (a_data[PTR_W-1:0]),
        .preset_val (preset_val),
        .off_q      (off_q)
    );

    assign afull1_off  = off_q[0];
    assign aempty1_off = off_q[1];
    assign afull2_off  = off_q[2];
    assign aempty2_off = off_q[3];

endmodule

// File: rtl/fol_checker.sv
// Assertion checker for the flag offset loader, bound to every instance.
// Keeps its own count of accepted serial bits.
module fol_checker
    import fol_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             mrst_n,
    input logic             prst_n,
    input logic             cfg_hi_en_n,
    input logic             cfg_lo_dat,
    input method_t          method,
    input logic [PTR_W-1:0] afull1_off,
    input logic [PTR_W-1:0] aempty1_off,
    input logic [PTR_W-1:0] afull2_off,
    input logic [PTR_W-1:0] aempty2_off,
    input logic             prog_done
);

    localparam int SER_BITS = 4 * PTR_W;
    localparam int CNT_W    = $clog2(SER_BITS + 1);

    logic             bit_take;
    logic [CNT_W-1:0] bits_seen;

    assign bit_take = (method == M_SERIAL) && prst_n && !prog_done && !cfg_hi_en_n;

    // Independent tally of serial bits accepted since master reset.
    always_ff @(posedge clk) begin
        if (!mrst_n)
            bits_seen <= '0;
        else if (bit_take)
            bits_seen <= bits_seen + CNT_W'(1);
    end

    AST_PRESET_UNIFORM: assert property (@(posedge clk) disable iff (!mrst_n)
        (method == M_PRESET && prog_done) |->
            (afull1_off == aempty1_off && afull1_off == afull2_off
             && afull1_off == aempty2_off
             && (afull1_off == PTR_W'(8) || afull1_off == PTR_W'(16)
                 || afull1_off == PTR_W'(64))));                              // R3

    AST_SERIAL_SHIFT: assert property (@(posedge clk) disable iff (!mrst_n)
        bit_take |=> (aempty2_off[0] == $past(cfg_lo_dat))
                  && (afull1_off == {$past(afull1_off[PTR_W-2:0]), $past(aempty1_off[PTR_W-1])})); // R5

    AST_SERIAL_COUNT: assert property (@(posedge clk) disable iff (!mrst_n)
        (method == M_SERIAL && $rose(prog_done)) |-> (bits_seen == CNT_W'(SER_BITS))); // R6

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!mrst_n)
        prog_done |=> prog_done && $stable({afull1_off, aempty1_off, afull2_off, aempty2_off})); // R7

    AST_PARTIAL_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> $stable(prog_done)
                 && $stable({afull1_off, aempty1_off, afull2_off, aempty2_off})); // R8

    AST_NO_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
        (method == M_SERIAL && cfg_hi_en_n) |=>
            $stable({afull1_off, aempty1_off, afull2_off, aempty2_off}));     // R9

endmodule

bind flag_offset_loader fol_checker #(.PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .mrst_n      (mrst_n),
    .prst_n      (prst_n),
    .cfg_hi_en_n (cfg_hi_en_n),
    .cfg_lo_dat  (cfg_lo_dat),
    .method      (method),
    .afull1_off  (afull1_off),
    .aempty1_off (aempty1_off),
    .afull2_off  (afull2_off),
    .aempty2_off (aempty2_off),
    .prog_done   (prog_done)
);

// File: tb/tb_flag_offset_loader.sv
`timescale 1ns/1ps
// Bench: three instances (depths 256, 512, 1024) share one stimulus; expected
// offsets are computed arithmetically from the requirements.
module tb_flag_offset_loader;

    logic        clk = 1'b0;
    logic        mrst_n = 1'b0, prst_n = 1'b1, serial_mode_n = 1'b1;
    logic        cfg_hi_en_n = 1'b1, cfg_lo_dat = 1'b0, a_wr = 1'b0;
    logic [35:0] a_data = '0;

    always #2 clk = ~clk;

    logic [7:0] f1_a, e1_a, f2_a, e2_a;
    logic [8:0] f1_b, e1_b, f2_b, e2_b;
    logic [9:0] f1_c, e1_c, f2_c, e2_c;
    logic       done_a, done_b, done_c;

    flag_offset_loader #(.DEPTH(256)) dut (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .serial_mode_n(serial_mode_n),
        .cfg_hi_en_n(cfg_hi_en_n), .cfg_lo_dat(cfg_lo_dat), .a_wr(a_wr), .a_data(a_data),
        .afull1_off(f1_a), .aempty1_off(e1_a), .afull2_off(f2_a), .aempty2_off(e2_a),
        .prog_done(done_a));

    flag_offset_loader #(.DEPTH(512)) dut_512 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .serial_mode_n(serial_mode_n),
        .cfg_hi_en_n(cfg_hi_en_n), .cfg_lo_dat(cfg_lo_dat), .a_wr(a_wr), .a_data(a_data),
        .afull1_off(f1_b), .aempty1_off(e1_b), .afull2_off(f2_b), .aempty2_off(e2_b),
        .prog_done(done_b));

    flag_offset_loader #(.DEPTH(1024)) dut_1024 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .serial_mode_n(serial_mode_n),
        .cfg_hi_en_n(cfg_hi_en_n), .cfg_lo_dat(cfg_lo_dat), .a_wr(a_wr), .a_data(a_data),
        .afull1_off(f1_c), .aempty1_off(e1_c), .afull2_off(f2_c), .aempty2_off(e2_c),
        .prog_done(done_c));

    // Field 3 = almost-full 1 ... field 0 = almost-empty 2 (chain order reversed).
    logic [3:0][9:0] offs [3];
    logic            dn   [3];
    assign offs[0] = {{2'b0, f1_a}, {2'b0, e1_a}, {2'b0, f2_a}, {2'b0, e2_a}};
    assign offs[1] = {{1'b0, f1_b}, {1'b0, e1_b}, {1'b0, f2_b}, {1'b0, e2_b}};
    assign offs[2] = {f1_c, e1_c, f2_c, e2_c};
    assign dn[0] = done_a;
    assign dn[1] = done_b;
    assign dn[2] = done_c;

    logic [3:0][9:0] exp_offs [3];
    logic            exp_dn   [3];

    int tests = 0, fails = 0, cycles = 0;
    bit finished = 0;

    function automatic int wid(input int k);
        return 8 + k;
    endfunction

    function automatic logic [63:0] msk(input int k);
        return (64'd1 << wid(k)) - 64'd1;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Compare every output of every instance against the expectation arrays.
    task automatic chk_all(input string tag);
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 4; i++)
                chk($sformatf("%s dut%0d field%0d", tag, k, i),
                    64'(offs[k][i]), 64'(exp_offs[k][i]));
            chk($sformatf("%s dut%0d done", tag, k), 64'(dn[k]), 64'(exp_dn[k]));
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_exp();
        for (int k = 0; k < 3; k++) begin
            exp_offs[k] = '0;
            exp_dn[k]   = 1'b0;
        end
    endtask

    // R1: two reset clocks, first with the opposite pins, last with the wanted ones.
    task automatic master_reset(input bit spm, input bit s1, input bit s0);
        mrst_n = 0; prst_n = 1; a_wr = 0;
        serial_mode_n = ~spm; cfg_hi_en_n = ~s1; cfg_lo_dat = ~s0;
        cyc();
        serial_mode_n = spm; cfg_hi_en_n = s1; cfg_lo_dat = s0;
        cyc();
        clear_exp();
        chk_all("R1 reset state");
        mrst_n = 1;
        if (!spm) cfg_hi_en_n = 1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    logic [39:0] stream;
    logic [9:0]  pv [4];
    logic [63:0] chain;
    int          nb;

    initial begin
        @(negedge clk);

        // R2 R3: each preset code, then R8 partial reset with write attempts.
        for (int code = 1; code < 4; code++) begin
            master_reset(1, code[1], code[0]);
            cyc();
            for (int k = 0; k < 3; k++) begin
                for (int i = 0; i < 4; i++)
                    exp_offs[k][i] = (code == 1) ? 10'd8 : (code == 2) ? 10'd16 : 10'd64;
                exp_dn[k] = 1'b1;
            end
            chk_all("R2 R3 preset");
            prst_n = 0; a_wr = 1; a_data = '1; cfg_hi_en_n = 0;
            cyc(); cyc();
            chk_all("R8 preset held in partial reset");
            prst_n = 1; a_wr = 0;
            cyc();
            chk_all("R7 preset after done");
        end

        // R4: parallel load, with a partial reset before the third word.
        master_reset(1, 0, 0);
        cyc();
        chk_all("R4 parallel idle");
        for (int n = 0; n < 4; n++) pv[n] = 10'(n * 157 + 3 + n * 512);
        for (int n = 0; n < 4; n++) begin
            if (n == 2) begin
                prst_n = 0; a_wr = 1; a_data = 36'hFFFFFFFFF;
                cyc(); cyc();
                chk_all("R8 parallel partial reset");
                prst_n = 1; a_wr = 0;
                cyc();
                chk_all("R8 parallel resume");
            end
            a_wr = 1; a_data = {26'h2ABCDEF, pv[n]};
            cyc();
            a_wr = 0; a_data = 36'h123456789;
            for (int k = 0; k < 3; k++) begin
                exp_offs[k][3 - n] = 10'(64'(pv[n]) & msk(k));
                exp_dn[k] = (n == 3);
            end
            chk_all("R4 parallel word");
            cyc();
            chk_all("R4 parallel no strobe");
        end
        a_wr = 1; a_data = 36'h0_5555_5555;
        cyc();
        a_wr = 0;
        chk_all("R7 parallel write after done");

        // R5 R6 R9: serial load of one 40-bit stream into all three depths.
        master_reset(0, 0, 0);
        for (int t = 0; t < 3; t++) begin
            cfg_lo_dat = t[0];
            cyc();
        end
        chk_all("R9 enable high");
        stream = 40'hC53A96E1B7;
        for (int b = 0; b < 40; b++) begin
            if (b == 20) begin
                prst_n = 0; cfg_hi_en_n = 0; cfg_lo_dat = 1;
                cyc();
                cfg_lo_dat = 0;
                cyc();
                chk_all("R8 serial partial reset");
                prst_n = 1; cfg_hi_en_n = 1;
            end
            if (b == 10) begin
                cfg_hi_en_n = 1; cfg_lo_dat = ~stream[39 - b];
                cyc();
                chk_all("R9 serial gap");
            end
            cfg_hi_en_n = 0; cfg_lo_dat = stream[39 - b];
            cyc();
            cfg_hi_en_n = 1;
            for (int k = 0; k < 3; k++) begin
                nb    = (b + 1 < 4 * wid(k)) ? b + 1 : 4 * wid(k);
                chain = 64'(stream) >> (40 - nb);
                for (int i = 0; i < 4; i++)
                    exp_offs[k][i] = 10'((chain >> (i * wid(k))) & msk(k));
                exp_dn[k] = (b + 1 >= 4 * wid(k));
            end
            chk_all("R5 R6 R7 serial bit");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule